// File: doc/BRIEF.md
# Timer Channel Capture/Match Unit

This block is the event hardware of one timer channel. It watches two free-running timebases supplied from outside. It keeps a match register that is compared against one of them, and a capture register that takes a snapshot of one of them when the channel pin changes level. Each comparison and each snapshot can use either timebase, chosen separately. Every channel of a timer array instantiates the same unit, so any channel can serve any timing function.

The match is a "has the time been reached" test, not an equality test. It fires once the selected timebase has passed the written value, counting modulo 2^16 within half a counter period. A late write therefore still produces its event instead of waiting a whole wrap. Each write arms the comparator for exactly one event. When the channel drives its pin, that event also changes the pin level according to an action code. A separate load strobe presets the pin level directly.

Top module: `tmr_chan_event_unit`

## Requirements
- R1: After reset, capt_evt_o, mtch_evt_o, pin_out_o and capt_val_o are all 0, and the comparator is disarmed: no match event occurs until the match register is written.
- R2: A write (mtch_wr_i high at a clock edge) loads mtch_val_i and arms the comparator, and no match event comes from that edge. mtch_evt_o is high for the cycle after the first later edge at which (selected timebase − match value) mod 2^16 is below 2^15. This includes a value already passed and a value across the wrap. A value 2^15 ahead does not fire. A second write before the event replaces the first.
- R3: A match event is one-shot: after it, no further match event occurs until the next write.
- R4: mtch_tb_sel_i = 0 compares against tb0_i; 1 compares against tb1_i.
- R5: edge_sel_i selects the capture condition: 0 none, 1 rising (0 to 1), 2 falling (1 to 0), 3 either. The pin level is compared with the level sampled at the previous edge, which is 0 after reset. capt_evt_o is high for exactly the cycle after the edge at which the new level is first sampled.
- R6: capt_tb_sel_i = 0 captures tb0_i and 1 captures tb1_i, independently of the match selection. capt_val_o holds the value present at the capturing edge until the next capture.
- R7: Captures occur only while pin_dir_out_i = 0. In output mode, pin transitions cause no capture event and leave capt_val_o unchanged.
- R8: At the edge that produces a match event, while pin_dir_out_i = 1, pin_out_o is updated by out_act_i: 0 keep, 1 drive high, 2 drive low, 3 toggle. In input mode the match event still occurs but pin_out_o does not change.
- R9: pin_load_i high at an edge sets pin_out_o to pin_load_val_i. It wins over a match action at the same edge.
- R10: pin_oe_o equals pin_dir_out_i in the same cycle.
- R11: A capture and a match event in the same cycle are both reported, each with its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb0_i | input | 16 | Timebase 0 |
| tb1_i | input | 16 | Timebase 1 |
| pin_i | input | 1 | Pin level, synchronous to clk |
| mtch_tb_sel_i | input | 1 | Match timebase select |
| capt_tb_sel_i | input | 1 | Capture timebase select |
| edge_sel_i | input | 2 | Capture edge condition |
| pin_dir_out_i | input | 1 | 1 = channel drives the pin |
| out_act_i | input | 2 | Pin action on a match |
| mtch_wr_i | input | 1 | Match register load strobe |
| mtch_val_i | input | 16 | Match value to load |
| pin_load_i | input | 1 | Pin level load strobe |
| pin_load_val_i | input | 1 | Pin level to load |
| capt_val_o | output | 16 | Capture register |
| capt_evt_o | output | 1 | Capture event pulse |
| mtch_evt_o | output | 1 | Match event pulse |
| pin_out_o | output | 1 | Driven pin level |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
A capture and a match event can land in the same cycle. The bench provokes this by arming a match four edges ahead on one timebase and raising the pin so that its rising edge is sampled at that same fourth edge, with capture taken from the other timebase. The scoreboard expects one item flagged as both events. The item carries the cycle and the captured value, which is the second timebase's value at that edge, so a design that drops either pulse or latches the wrong counter miscompares. A match write and a firing comparison can also coincide. That case is judged by requiring a single event, placed relative to the second written value.

// File: rtl/tce_pkg.sv
// Shared encodings for the timer channel event unit.
// Assumes: control fields arrive as plain 2-bit vectors and are cast here.
package tce_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_HIGH = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_FLIP = 2'd3
    } pin_act_e;
endpackage

// File: rtl/tce_tb_mux.sv
// Picks one of two timebases for a comparator or capture path.
// Assumes: both timebases share the width TW.
module tce_tb_mux #(
    parameter int TW = 16
) (
    input  logic          sel_i,
    input  logic [TW-1:0] tb0_i,
    input  logic [TW-1:0] tb1_i,
    output logic [TW-1:0] tb_o
);
    // select the requested counter
    always_comb tb_o = sel_i ? tb1_i : tb0_i;
endmodule

// File: rtl/tce_match.sv
// One-shot modulo greater-or-equal comparator with its match register.
// Assumes: the timebase moves by less than half its range between write and use.
module tce_match #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [TW-1:0] val_i,
    input  logic [TW-1:0] tb_i,
    output logic          hit_o,
    output logic          evt_o
);
    logic [TW-1:0] mreg;
    logic          armed;
    logic [TW-1:0] diff;

    // distance from match value to timebase, top bit clear means reached
    always_comb begin
        diff  = tb_i - mreg;
        hit_o = armed && !wr_i && !diff[TW-1];
    end

    // register load, arming and event pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreg  <= '0;
            armed <= 1'b0;
            evt_o <= 1'b0;
        end else begin
            evt_o <= hit_o;
            if (wr_i) begin
                mreg  <= val_i;
                armed <= 1'b1;
            end else if (hit_o) begin
                armed <= 1'b0;
            end
        end
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
    a_r2_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !evt_o);
endmodule

// File: rtl/tce_capture.sv
// Pin edge qualifier and capture register.
// Assumes: pin_i is already synchronous to clk; previous level resets to 0.
module tce_capture #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_i,
    input  logic          out_mode_i,
    input  logic [1:0]    edge_sel_i,
    input  logic [TW-1:0] tb_i,
    output logic [TW-1:0] capt_val_o,
    output logic          capt_evt_o
);
    import tce_pkg::*;

    logic       pin_q;
    logic       rise;
    logic       fall;
    logic       take;
    edge_mode_e mode;

    // qualify the sampled transition against the edge condition
    always_comb begin
        mode = edge_mode_e'(edge_sel_i);
        rise = pin_i && !pin_q;
        fall = !pin_i && pin_q;
        unique case (mode)
            EDGE_RISE: take = rise;
            EDGE_FALL: take = fall;
            EDGE_ANY:  take = rise || fall;
            default:   take = 1'b0;
        endcase
        if (out_mode_i) take = 1'b0;
    end

    // pin history, snapshot and event pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q      <= 1'b0;
            capt_val_o <= '0;
            capt_evt_o <= 1'b0;
        end else begin
            pin_q      <= pin_i;
            capt_evt_o <= take;
            if (take) capt_val_o <= tb_i;
        end
    end

    a_r6_value_moves_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(capt_val_o) |-> capt_evt_o);
    a_r5_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_evt_o && $past(edge_sel_i) == EDGE_RISE) |-> $past(pin_i));
    a_r7_output_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        capt_evt_o |-> !$past(out_mode_i));
endmodule

// File: rtl/tce_pin_out.sv
// Output pin level register driven by match actions and a direct load.
// Assumes: hit_i is the comparator's same-edge firing condition.
module tce_pin_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic       out_mode_i,
    input  logic [1:0] act_i,
    input  logic       load_i,
    input  logic       load_val_i,
    output logic       pin_o
);
    import tce_pkg::*;

    logic nxt;

    // next level: load first, then the match action in output mode
    always_comb begin
        nxt = pin_o;
        if (load_i) begin
            nxt = load_val_i;
        end else if (hit_i && out_mode_i) begin
            unique case (pin_act_e'(act_i))
                ACT_HIGH: nxt = 1'b1;
                ACT_LOW:  nxt = 1'b0;
                ACT_FLIP: nxt = !pin_o;
                default:  nxt = pin_o;
            endcase
        end
    end

    // level register
    always_ff @(posedge clk) begin
        if (!rst_n) pin_o <= 1'b0;
        else        pin_o <= nxt;
    end

    a_r9_pin_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_o) |-> ($past(hit_i) || $past(load_i)));
endmodule

// File: rtl/tmr_chan_event_unit.sv
// One timer channel: capture and match on independently chosen timebases,
// with pin output control. Assumes synchronous pin input and active-low reset.
module tmr_chan_event_unit #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tb0_i,
    input  logic [TW-1:0] tb1_i,
    input  logic          pin_i,
    input  logic          mtch_tb_sel_i,
    input  logic          capt_tb_sel_i,
    input  logic [1:0]    edge_sel_i,
    input  logic          pin_dir_out_i,
    input  logic [1:0]    out_act_i,
    input  logic          mtch_wr_i,
    input  logic [TW-1:0] mtch_val_i,
    input  logic          pin_load_i,
    input  logic          pin_load_val_i,
    output logic [TW-1:0] capt_val_o,
    output logic          capt_evt_o,
    output logic          mtch_evt_o,
    output logic          pin_out_o,
    output logic          pin_oe_o
);
    localparam int NPATH = 2;

    logic [NPATH-1:0]   path_sel;
    logic [TW-1:0]      path_tb [NPATH];
    logic               hit;

    always_comb begin
        path_sel[0] = mtch_tb_sel_i;
        path_sel[1] = capt_tb_sel_i;
    end

    for (genvar g = 0; g < NPATH; g++) begin : g_tbsel
        tce_tb_mux #(.TW(TW)) u_mux (
            .sel_i (path_sel[g]),
            .tb0_i (tb0_i),
            .tb1_i (tb1_i),
            .tb_o  (path_tb[g])
        );
    end

    tce_match #(.TW(TW)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (mtch_wr_i),
        .val_i (mtch_val_i),
        .tb_i  (path_tb[0]),
        .hit_o (hit),
        .evt_o (mtch_evt_o)
    );

    tce_capture #(.TW(TW)) u_capt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .out_mode_i (pin_dir_out_i),
        .edge_sel_i (edge_sel_i),
        .tb_i       (path_tb[1]),
        .capt_val_o (capt_val_o),
        .capt_evt_o (capt_evt_o)
    );

    tce_pin_out u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .out_mode_i (pin_dir_out_i),
        .act_i      (out_act_i),
        .load_i     (pin_load_i),
        .load_val_i (pin_load_val_i),
        .pin_o      (pin_out_o)
    );

    // output enable follows the direction control
    always_comb pin_oe_o = pin_dir_out_i;
endmodule

// File: tb/tmr_chan_event_unit_bench.sv
module tmr_chan_event_unit_bench;
    typedef struct packed {
        logic [1:0]  kind;   // bit0 capture, bit1 match
        logic [31:0] cyc;
        logic [15:0] cval;
        logic        pchk;
        logic        pin;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] tb_cnt = '0;
    logic [15:0] base0 = 16'h0100;
    logic [15:0] base1 = 16'h7000;
    logic [15:0] tb0, tb1;
    logic pin_i = 0, mtch_tb_sel = 0, capt_tb_sel = 0, pin_dir = 0;
    logic [1:0] edge_sel = 0, out_act = 0;
    logic mtch_wr = 0, pin_load = 0, pin_load_val = 0;
    logic [15:0] mtch_val = '0;
    logic [15:0] capt_val;
    logic capt_evt, mtch_evt, pin_out, pin_oe;

    int   cyc = 0;
    int   nvec = 0;
    int   nbad = 0;
    bit   done = 0;
    exp_t q[$];
    string qtag[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tb_cnt <= tb_cnt + 16'd1;
    assign tb0 = tb_cnt + base0;
    assign tb1 = tb_cnt * 16'd3 + base1;

    tmr_chan_event_unit u_tmr_chan_event_unit (
        .clk(clk), .rst_n(rst_n), .tb0_i(tb0), .tb1_i(tb1), .pin_i(pin_i),
        .mtch_tb_sel_i(mtch_tb_sel), .capt_tb_sel_i(capt_tb_sel),
        .edge_sel_i(edge_sel), .pin_dir_out_i(pin_dir), .out_act_i(out_act),
        .mtch_wr_i(mtch_wr), .mtch_val_i(mtch_val), .pin_load_i(pin_load),
        .pin_load_val_i(pin_load_val), .capt_val_o(capt_val),
        .capt_evt_o(capt_evt), .mtch_evt_o(mtch_evt), .pin_out_o(pin_out),
        .pin_oe_o(pin_oe)
    );

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input string tag, input logic [1:0] k, input int c,
                        input logic [15:0] v, input logic pc, input logic p);
        exp_t e;
        e.kind = k; e.cyc = c; e.cval = v; e.pchk = pc; e.pin = p;
        q.push_back(e);
        qtag.push_back(tag);
    endtask

    task automatic drain(input string tag);
        check({tag, " pending expected events"}, q.size(), 0);
    endtask

    // value each timebase shows at the next clock edge
    function automatic logic [15:0] tb0n(); return tb0; endfunction
    function automatic logic [15:0] tb1n(); return tb1; endfunction

    task automatic wr_match(input logic sel, input logic [15:0] m);
        mtch_tb_sel = sel; mtch_val = m; mtch_wr = 1;
        step();
        mtch_wr = 0;
    endtask

    // monitor: pop and compare as events appear
    always @(negedge clk) begin
        #2;
        if (rst_n && (capt_evt || mtch_evt)) begin
            nvec++;
            if (q.size() == 0) begin
                nbad++;
                $display("FAIL unexpected event at cycle %0d actual kind=%0d expected none",
                         cyc, {mtch_evt, capt_evt});
            end else begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = qtag.pop_front();
                if ({mtch_evt, capt_evt} !== e.kind || cyc != int'(e.cyc) ||
                    (capt_evt && capt_val !== e.cval) || (e.pchk && pin_out !== e.pin)) begin
                    nbad++;
                    $display("FAIL %s actual kind=%0d cyc=%0d cval=%0h pin=%0b expected kind=%0d cyc=%0d cval=%0h pin=%0b",
                             t, {mtch_evt, capt_evt}, cyc, capt_val, pin_out,
                             e.kind, e.cyc, e.cval, e.pin);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int e;
        logic [15:0] m, cv, kept;
        wait_n(5);
        rst_n = 1;
        step();
        // R1 reset state
        check("R1 capt_evt", capt_evt, 0);
        check("R1 mtch_evt", mtch_evt, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 capt_val", capt_val, 0);
        pin_dir = 1; out_act = 1;
        // R10 enable follows direction
        check("R10 oe high", pin_oe, 1);
        wait_n(20);
        drain("R1 disarmed");
        check("R1 pin unchanged", pin_out, 0);

        // R2 R8 future match, drive high
        e = cyc + 1; m = tb0n() + 16'd5;
        push("R2 match d5", 2'b10, e + 5, 0, 1, 1);
        wr_match(0, m);
        wait_n(10);
        drain("R2");
        // R3 one-shot
        wait_n(40);
        drain("R3 no refire");
        check("R3 pin held", pin_out, 1);

        // R4 R8 timebase 1 and toggle
        out_act = 3;
        e = cyc + 1; m = tb1n() + 16'd12;
        push("R4 tb1 match toggle", 2'b10, e + 4, 0, 1, 0);
        wr_match(1, m);
        wait_n(8);
        drain("R4");

        // R2 value already passed, drive high
        out_act = 1;
        e = cyc + 1; m = tb0n() - 16'd100;
        push("R2 passed value", 2'b10, e + 1, 0, 1, 1);
        wr_match(0, m);
        wait_n(4);
        // R8 keep
        out_act = 0;
        e = cyc + 1; m = tb0n() + 16'd2;
        push("R8 keep", 2'b10, e + 2, 0, 1, 1);
        wr_match(0, m);
        wait_n(5);
        // R8 drive low
        out_act = 2;
        e = cyc + 1; m = tb0n() + 16'd2;
        push("R8 low", 2'b10, e + 2, 0, 1, 0);
        wr_match(0, m);
        wait_n(5);
        drain("R8");

        // R2 across the wrap
        out_act = 3;
        base0 = 16'hFFF0 - tb_cnt;
        e = cyc + 1;
        push("R2 wrap", 2'b10, e + 20, 0, 1, 1);
        wr_match(0, 16'h0004);
        wait_n(25);
        drain("R2 wrap");

        // R2 half range ahead does not fire
        m = tb0n() + 16'h8000;
        wr_match(0, m);
        wait_n(60);
        drain("R2 half range");

        // R2 second write replaces first at a firing edge
        out_act = 2;
        e = cyc + 1;
        mtch_tb_sel = 0; mtch_val = tb0n() - 16'd10; mtch_wr = 1;
        step();
        mtch_val = tb0n() + 16'd3;
        step();
        mtch_wr = 0;
        push("R2 rewrite", 2'b10, e + 4, 0, 1, 0);
        wait_n(8);
        drain("R2 rewrite");

        // R8 input mode: event, pin untouched
        pin_dir = 0; out_act = 1;
        step();
        check("R10 oe low", pin_oe, 0);
        e = cyc + 1; m = tb0n() + 16'd2;
        push("R8 input mode", 2'b10, e + 2, 0, 1, 0);
        wr_match(0, m);
        wait_n(6);
        drain("R8 input mode");

        // R5 R6 rising on tb0
        edge_sel = 1; capt_tb_sel = 0;
        pin_i = 1; e = cyc + 1; cv = tb0n();
        push("R6 rise tb0", 2'b01, e, cv, 0, 0);
        wait_n(4);
        pin_i = 0;
        wait_n(4);
        drain("R5 fall ignored");
        check("R6 value held", capt_val, cv);

        // R5 R6 falling on tb1
        edge_sel = 2; capt_tb_sel = 1;
        pin_i = 1;
        wait_n(3);
        pin_i = 0; e = cyc + 1; cv = tb1n();
        push("R6 fall tb1", 2'b01, e, cv, 0, 0);
        wait_n(4);
        drain("R5 fall");

        // R5 either edge
        edge_sel = 3; capt_tb_sel = 0;
        pin_i = 1; e = cyc + 1;
        push("R5 any rise", 2'b01, e, tb0n(), 0, 0);
        wait_n(2);
        pin_i = 0; e = cyc + 1; cv = tb0n();
        push("R5 any fall", 2'b01, e, cv, 0, 0);
        wait_n(4);
        drain("R5 any");

        // R5 none
        edge_sel = 0;
        pin_i = 1; wait_n(2); pin_i = 0; wait_n(3);
        drain("R5 none");
        check("R5 none value", capt_val, cv);

        // R7 output mode ignores pin
        edge_sel = 3; pin_dir = 1;
        kept = capt_val;
        pin_i = 1; wait_n(2); pin_i = 0; wait_n(2);
        pin_dir = 0; wait_n(2);
        drain("R7");
        check("R7 value kept", capt_val, kept);

        // R9 direct load
        pin_dir = 1;
        pin_load = 1; pin_load_val = 1;
        step();
        pin_load = 0;
        check("R9 load", pin_out, 1);
        // R9 load beats action at the same edge
        out_act = 1;
        e = cyc + 1; m = tb0n() + 16'd3;
        push("R9 load wins", 2'b10, e + 3, 0, 1, 0);
        wr_match(0, m);
        wait_n(2);
        pin_load = 1; pin_load_val = 0;
        step();
        pin_load = 0;
        wait_n(3);
        check("R9 pin after", pin_out, 0);
        drain("R9");

        // R11 capture and match in one cycle
        pin_dir = 0; out_act = 0; edge_sel = 1; capt_tb_sel = 1;
        e = cyc + 1; m = tb0n() + 16'd4;
        push("R11 both", 2'b11, e + 4, tb1n() + 16'd12, 0, 0);
        wr_match(0, m);
        wait_n(3);
        pin_i = 1;
        wait_n(5);
        drain("R11");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule